// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers ten event sources into one level-sensitive interrupt line. Each source has a sticky status flag and a mask flag. Hardware events set status flags. Software reads and clears them over a simple 32-bit register bus, which has a write enable, a byte address, write data and combinational read data.

The mask cannot be written directly. Software unmasks sources by writing ones to an enable register and masks them by writing ones to a disable register. A trigger register lets software raise status flags without hardware, which is used to test interrupt handlers. The interrupt line is registered. It is high whenever at least one status flag is set whose mask flag is clear.

Top module: `irq_ctrl_top`

## Requirements
- R1: Register map, by byte address:
  - 0x00: status.
  - 0x04: mask.
  - 0x08: enable.
  - 0x0C: disable.
  - 0x10: trigger.

  Any other address, including any address with bits [1:0] not zero, reads as zero, and a write there changes nothing.
- R2: Status and mask hold one bit per source, in bits [9:0], with bit n belonging to source n. Read data bits [31:10] are always zero, and write data bits [31:10] have no effect.
- R3: After a synchronous active-low reset, status is 0x000, mask is 0x3FF (all sources masked), and the interrupt line is low.
- R4: Writing to status clears every status bit written as 1 and leaves the bits written as 0 unchanged.
- R5: A write to the mask address leaves the mask unchanged.
- R6: Writing to enable clears every mask bit written as 1. Mask bits written as 0 are unchanged.
- R7: Writing to disable sets every mask bit written as 1. Mask bits written as 0 are unchanged.
- R8: Writing to trigger sets every status bit written as 1. Status bits written as 0 are unchanged.
- R9: Reads of enable, disable and trigger return zero.
- R10: An event input that is high at a clock edge sets its status bit at that edge. When an event arrives in the same cycle as a software clear of the same bit, the bit stays set.
- R11: The interrupt line equals the OR of (status AND NOT mask), as that value stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_evt | input | 10 | Event inputs, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets these corner cases:
- **Event against clear.** An event on the same bit and in the same cycle as a write-one-to-clear. A design that let the clear win would lose that event.
- **Partial writes.** Writes that set only some bits, aimed at clear, enable and disable. A design that wrote the whole value, instead of acting only on the ones, would disturb neighbouring bits.
- **Interrupt latency.** The interrupt line is sampled the cycle before it should change and the cycle after. A combinational or doubly registered line would show up as early or late.
- **Ignored writes.** Direct writes to the mask, writes to reserved bits and writes to unmapped addresses are each followed by a read back. This shows whether anything was altered.

// File: rtl/irq_ctrl_pkg.sv
// Package: constants shared by the interrupt controller and its checker.
// Assumes word-aligned register slots, with the slot index in bus address bits [ADDR_W-1:2].
package irq_ctrl_pkg;

    localparam int NUM_REGS    = 5;
    // Slot indices; the byte address of a slot is its index times four.
    localparam int IDX_STATUS  = 0;
    localparam int IDX_MASK    = 1;
    localparam int IDX_ENABLE  = 2;
    localparam int IDX_DISABLE = 3;
    localparam int IDX_TRIGGER = 4;

endpackage

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Turns a byte address into one-hot slot hits for reads, and into write hits gated by the write strobe.
// Assumes an address with bits [1:0] not zero selects no slot.
module irq_reg_decode #(
    parameter int ADDR_W = 8,
    parameter int NREG   = irq_ctrl_pkg::NUM_REGS
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    output logic [NREG-1:0]   rd_hit,
    output logic [NREG-1:0]   wr_hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;

    // Only word-aligned accesses can select a slot.
    assign aligned = (bus_addr[1:0] == 2'b00);

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_slot
            // Slot g is hit when the word index equals g.
            assign rd_hit[g] = aligned && (bus_addr[ADDR_W-1:2] == IDX_W'(g));
            assign wr_hit[g] = rd_hit[g] && bus_we;
        end
    endgenerate
endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Holds one sticky status flag per source.
// Events and software trigger set flags; write-one-to-clear removes them.
// Assumes set and clear can coincide on a bit, in which case the set wins.
module irq_status_bank #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            set_stb,
    input  logic            clr_stb,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] status_q
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_bit
            // Per-bit flag: a set (event or trigger) beats a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status_q[g] <= 1'b0;
                end else if (evt[g] || (set_stb && wbits[g])) begin
                    status_q[g] <= 1'b1;
                end else if (clr_stb && wbits[g]) begin
                    status_q[g] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_mask_bank.sv
// Module: irq_mask_bank
// Holds one mask flag per source; reset masks every source.
// Changed only by the enable strobe (clear ones) and the disable strobe (set ones).
// Assumes at most one strobe per cycle, since one bus write per cycle.
module irq_mask_bank #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_stb,
    input  logic            dis_stb,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] mask_q
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_bit
            // Per-bit mask: disable sets, enable clears, otherwise hold.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q[g] <= 1'b1;
                end else if (dis_stb && wbits[g]) begin
                    mask_q[g] <= 1'b1;
                end else if (en_stb && wbits[g]) begin
                    mask_q[g] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_line_gen.sv
// Module: irq_line_gen
// Produces the registered interrupt request from the status and mask flags.
// Assumes both inputs are register outputs, so the line lags them by exactly one cycle.
module irq_line_gen #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] status_q,
    input  logic [NSRC-1:0] mask_q,
    output logic            irq_o
);
    logic pending;

    // Any unmasked pending source requests an interrupt.
    assign pending = |(status_q & ~mask_q);

    // Register the request, so the output is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pending;
    end
endmodule

// File: rtl/irq_ctrl_top.sv
// Module: irq_ctrl_top
// Interrupt status and mask controller for NSRC sources on a 32-bit register bus.
// Assumes NSRC < DATA_W, single-cycle writes and combinational reads.
module irq_ctrl_top #(
    parameter int NSRC   = 10,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_evt,
    output logic              irq_o
);
    import irq_ctrl_pkg::*;

    logic [NUM_REGS-1:0] rd_hit;
    logic [NUM_REGS-1:0] wr_hit;
    logic [NSRC-1:0]     wbits;
    logic [NSRC-1:0]     status_q;
    logic [NSRC-1:0]     mask_q;
    logic                unused_sig;

    // Only the per-source bits of write data have meaning.
    assign wbits      = bus_wdata[NSRC-1:0];
    assign unused_sig = ^{bus_wdata[DATA_W-1:NSRC], rd_hit[IDX_TRIGGER:IDX_ENABLE]};

    irq_reg_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_decode (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit)
    );

    irq_status_bank #(.NSRC(NSRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt),
        .set_stb  (wr_hit[IDX_TRIGGER]),
        .clr_stb  (wr_hit[IDX_STATUS]),
        .wbits    (wbits),
        .status_q (status_q)
    );

    irq_mask_bank #(.NSRC(NSRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_stb   (wr_hit[IDX_ENABLE]),
        .dis_stb  (wr_hit[IDX_DISABLE]),
        .wbits    (wbits),
        .mask_q   (mask_q)
    );

    irq_line_gen #(.NSRC(NSRC)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq_o    (irq_o)
    );

    // Read mux: only status and mask return data; everything else reads zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit[IDX_STATUS]) bus_rdata[NSRC-1:0] = status_q;
        if (rd_hit[IDX_MASK])   bus_rdata[NSRC-1:0] = mask_q;
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
// Module: irq_ctrl_checker
// Property checks for irq_ctrl_top, attached by bind. It observes the ports and the two flag registers.
module irq_ctrl_checker #(
    parameter int NSRC   = 10,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NSRC-1:0]   src_evt,
    input logic [NSRC-1:0]   status_q,
    input logic [NSRC-1:0]   mask_q,
    input logic              irq_o
);
    import irq_ctrl_pkg::*;

    localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(IDX_ENABLE * 4);
    localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(IDX_DISABLE * 4);
    localparam logic [ADDR_W-1:0] A_TRIGGER = ADDR_W'(IDX_TRIGGER * 4);

    AST_MASK_RESET: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && status_q == '0 && !irq_o)); // R3

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NSRC] == '0); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == A_ENABLE || bus_addr == A_DISABLE)) |=> $stable(mask_q)); // R5

    AST_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_TRIGGER) |=>
            ((status_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R8

    AST_ACTION_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ENABLE || bus_addr == A_DISABLE || bus_addr == A_TRIGGER) |-> bus_rdata == '0); // R9

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((status_q & $past(src_evt)) == $past(src_evt))); // R10

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(status_q & ~mask_q))); // R11
endmodule

bind irq_ctrl_top irq_ctrl_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_evt   (src_evt),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq_o     (irq_o)
);

// File: tb/tb_irq_ctrl_top.sv
// Directed bench for irq_ctrl_top: one task per scenario, each checking its own results.
module tb_irq_ctrl_top;
    localparam int NSRC = 10;
    localparam logic [7:0] A_ST = 8'h00, A_MK = 8'h04, A_EN = 8'h08,
                           A_DI = 8'h0C, A_TR = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] src_evt = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; src_evt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write cycle; returns at the negedge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(A_ST, v); check("R3 status reset", v, 32'h0);
        rd(A_MK, v); check("R3 mask reset", v, 32'h3FF);
        check("R3 irq reset", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        do_reset();
        wr(A_TR, 32'h3FF);
        wr(A_ST, 32'h0A5);
        rd(A_ST, v); check("R4 partial clear", v, 32'h35A);
        wr(A_ST, 32'hFFFF_FC00);
        rd(A_ST, v); check("R2 reserved write bits ignored", v, 32'h35A);
        wr(A_ST, 32'h35A);
        rd(A_ST, v); check("R4 full clear", v, 32'h0);
    endtask

    task automatic t_mask_ro();
        logic [31:0] v;
        do_reset();
        wr(A_MK, 32'h0);
        rd(A_MK, v); check("R5 direct mask write ignored", v, 32'h3FF);
    endtask

    task automatic t_enable_disable();
        logic [31:0] v;
        do_reset();
        wr(A_EN, 32'h00F);
        rd(A_MK, v); check("R6 enable clears ones", v, 32'h3F0);
        wr(A_EN, 32'h300);
        rd(A_MK, v); check("R6 enable keeps zeros", v, 32'h0F0);
        wr(A_DI, 32'h003);
        rd(A_MK, v); check("R7 disable sets ones", v, 32'h0F3);
        rd(A_ST, v); check("R6 mask ops leave status", v, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        do_reset();
        wr(A_TR, 32'h201);
        rd(A_ST, v); check("R8 trigger sets", v, 32'h201);
        wr(A_TR, 32'hFFFF_F810);
        rd(A_ST, v); check("R8 trigger accumulates", v, 32'h211);
        rd(A_ST, v); check("R2 read upper zero", v & 32'hFFFF_FC00, 32'h0);
    endtask

    task automatic t_action_reads();
        logic [31:0] v;
        do_reset();
        wr(A_TR, 32'h3FF);
        rd(A_EN, v); check("R9 enable reads zero", v, 32'h0);
        rd(A_DI, v); check("R9 disable reads zero", v, 32'h0);
        rd(A_TR, v); check("R9 trigger reads zero", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_reset();
        wr(8'h14, 32'h3FF);
        wr(8'h09, 32'h3FF);
        wr(8'h12, 32'h3FF);
        rd(A_ST, v); check("R1 unmapped write no status change", v, 32'h0);
        rd(A_MK, v); check("R1 unmapped write no mask change", v, 32'h3FF);
        wr(A_TR, 32'h3FF);
        rd(8'h14, v); check("R1 unmapped read zero", v, 32'h0);
        rd(8'h01, v); check("R1 misaligned read zero", v, 32'h0);
    endtask

    task automatic t_event_priority();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        src_evt = 10'h040;
        @(negedge clk);
        src_evt = '0;
        rd(A_ST, v); check("R10 event sets status", v, 32'h040);
        wr(A_TR, 32'h002);
        @(negedge clk);
        src_evt = 10'h040;
        bus_we = 1'b1; bus_addr = A_ST; bus_wdata = 32'h042;
        @(negedge clk);
        bus_we = 1'b0; src_evt = '0;
        rd(A_ST, v); check("R10 event beats clear", v, 32'h040);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        wr(A_TR, 32'h020);
        @(negedge clk);
        check("R11 masked source no irq", {31'b0, irq_o}, 32'h0);
        wr(A_EN, 32'h008);
        wr(A_TR, 32'h008);
        check("R11 irq not yet high", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R11 irq high one cycle later", {31'b0, irq_o}, 32'h1);
        wr(A_DI, 32'h008);
        check("R11 irq still high after mask", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R11 irq low after mask", {31'b0, irq_o}, 32'h0);
        wr(A_EN, 32'h020);
        @(negedge clk);
        check("R11 unmasking pending raises irq", {31'b0, irq_o}, 32'h1);
        wr(A_ST, 32'h020);
        @(negedge clk);
        check("R11 clear drops irq", {31'b0, irq_o}, 32'h0);
        rd(A_ST, v); check("R11 status after clear", v, 32'h008);
    endtask

    initial begin
        t_reset();
        t_w1c();
        t_mask_ro();
        t_enable_disable();
        t_trigger();
        t_action_reads();
        t_unmapped();
        t_event_priority();
        t_irq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule